// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in external memory. The virtual page number is split into two 10-bit indices. The upper index picks an entry in the top-level table, whose base comes from a root-base input. That entry names the 4 KB page that holds one second-level table. The lower index then picks the entry in that second-level page that carries the frame number. The 12-bit page offset passes through to the result unchanged.

A client hands in one translation at a time through a valid/ready request channel. The walker issues at most two dependent reads on a single memory read port and accepts any read latency. It then presents either a physical address or a fault on a response channel and holds it until the client takes it. Each table entry is 32 bits wide. Bits 31:12 hold a frame number and bit 0 is the present flag. A cleared present flag at either level stops the walk with a page fault that names the level.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R2: The first read of a walk goes to the captured root base plus 4 times virtual address bits 31:22.
- R3: The second read goes to {first entry bits 31:12, 12'h000} plus 4 times virtual address bits 21:12. It is issued only after the first entry returns with bit 0 set.
- R4: When both entries have bit 0 set, the response has `rsp_fault`=0, `rsp_level`=0 and `rsp_paddr` = {second entry bits 31:12, virtual address bits 11:0}.
- R5: When the first entry has bit 0 clear, the walk ends after that single read with `rsp_fault`=1, `rsp_level`=0 and `rsp_paddr`=0.
- R6: When the second entry has bit 0 clear, the walk ends after two reads with `rsp_fault`=1, `rsp_level`=1 and `rsp_paddr`=0.
- R7: `rsp_vaddr` returns the virtual address of the request, on success and on fault alike.
- R8: `mem_req` and `mem_addr` hold steady until `mem_rvalid` arrives, for any latency of one or more cycles. A `mem_rvalid` pulse while `mem_req` is low has no effect.
- R9: The response holds steady while `rsp_ready` is low. No new request is accepted (`req_ready`=0) from acceptance until the response is taken.
- R10: `root_base` is sampled when the request is accepted. Later changes to it do not alter the walk in progress.
- R11: Entry bits 11:1 are ignored at both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_base | input | 32 | Physical base of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req | output | 1 | Table read outstanding |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid, one pulse per read |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Page fault |
| rsp_level | output | 1 | Faulting level: 0 top, 1 second (0 when no fault) |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_vaddr | output | 32 | Virtual address of this result |

## Verification
A walk-state register holding the wrong value shows up within one read. The read count per walk changes, or the second read address is formed from the wrong base, and the bench compares both on every transaction. A wrongly captured address or entry corrupts `rsp_paddr`, `rsp_level` or `rsp_vaddr` at the very next response. A mishandled stall or stray read pulse shows up during the cycles in which the bench holds `rsp_ready` low or stretches read latency. In those cycles the response or the read address moves when it should not.

// File: rtl/pt_walker_pkg.sv
// Package: shared types for the two-level page table walker.
// Assumes nothing beyond standard SystemVerilog.
package pt_walker_pkg;

    // Walk sequencing states
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_OUTER = 2'd1,
        WS_INNER = 2'd2,
        WS_DONE  = 2'd3
    } walk_state_e;

    // Table level a read or a fault belongs to
    typedef enum logic {
        LVL_TOP    = 1'b0,
        LVL_SECOND = 1'b1
    } walk_level_e;

endpackage

// File: rtl/pt_va_split.sv
// Module: pt_va_split
// Splits a virtual address into top index, second index and page offset.
// Assumes VA_W = 2*IDX_W + OFF_W with the top index in the most significant bits.
module pt_va_split #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int VA_W = 2 * IDX_W + OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] sec_idx,
    output logic [OFF_W-1:0] page_off
);

    // Field extraction
    always_comb begin
        top_idx  = vaddr[VA_W-1 -: IDX_W];
        sec_idx  = vaddr[OFF_W+IDX_W-1 -: IDX_W];
        page_off = vaddr[OFF_W-1:0];
    end

endmodule

// File: rtl/pt_entry_addr.sv
// Module: pt_entry_addr
// Forms the byte address of a table entry as base + index * entry size.
// Assumes entries are 2**ENT_LOG2 bytes and the sum fits in PA_W bits.
module pt_entry_addr #(
    parameter int PA_W     = 32,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [PA_W-1:0]  table_base,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  entry_addr
);

    localparam int PAD_W = PA_W - IDX_W - ENT_LOG2;

    // Scaled index added to the table base
    always_comb begin
        entry_addr = table_base + {{PAD_W{1'b0}}, index, {ENT_LOG2{1'b0}}};
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
// Module: pt_walk_ctrl
// Sequences one walk: capture request, read top entry, read second entry,
// present the result. Holds each read until memory answers, ignores read
// data when no read is outstanding, and holds the result until taken.
// Assumes at most one read outstanding and mem_rvalid pulses once per read.
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int VA_W = 2 * IDX_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] root_base,
    output logic            req_ready,
    output logic            mem_req,
    output walk_level_e     read_level,
    input  logic            mem_rvalid,
    input  logic [PA_W-1:0] mem_rdata,
    input  logic            rsp_ready,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic            rsp_level,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [VA_W-1:0] va_q,
    output logic [PA_W-1:0] root_q,
    output logic [PA_W-1:0] sec_base_q
);

    walk_state_e     state_q;
    logic            fault_q;
    logic            level_q;
    logic [PA_W-1:0] paddr_q;
    logic            present;
    logic [PA_W-OFF_W-1:0] frame;

    // Decode the present flag and frame number of the returned entry
    always_comb begin
        present = mem_rdata[0];
        frame   = mem_rdata[PA_W-1:OFF_W];
    end

    // Walk state and captured values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= WS_IDLE;
            va_q       <= '0;
            root_q     <= '0;
            sec_base_q <= '0;
            fault_q    <= 1'b0;
            level_q    <= 1'b0;
            paddr_q    <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        root_q  <= root_base;
                        state_q <= WS_OUTER;
                    end
                end
                WS_OUTER: begin
                    if (mem_rvalid) begin
                        if (!present) begin
                            fault_q <= 1'b1;
                            level_q <= LVL_TOP;
                            paddr_q <= '0;
                            state_q <= WS_DONE;
                        end else begin
                            sec_base_q <= {frame, {OFF_W{1'b0}}};
                            state_q    <= WS_INNER;
                        end
                    end
                end
                WS_INNER: begin
                    if (mem_rvalid) begin
                        if (!present) begin
                            fault_q <= 1'b1;
                            level_q <= LVL_SECOND;
                            paddr_q <= '0;
                        end else begin
                            fault_q <= 1'b0;
                            level_q <= 1'b0;
                            paddr_q <= {frame, va_q[OFF_W-1:0]};
                        end
                        state_q <= WS_DONE;
                    end
                end
                WS_DONE: begin
                    if (rsp_ready) begin
                        state_q <= WS_IDLE;
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Handshake and read-port outputs from the state
    always_comb begin
        req_ready  = (state_q == WS_IDLE);
        mem_req    = (state_q == WS_OUTER) || (state_q == WS_INNER);
        read_level = (state_q == WS_INNER) ? LVL_SECOND : LVL_TOP;
        rsp_valid  = (state_q == WS_DONE);
        rsp_fault  = fault_q;
        rsp_level  = level_q;
        rsp_paddr  = paddr_q;
    end

endmodule

// File: rtl/pt_walker.sv
// Module: pt_walker (top)
// Two-level page table walker: one translation at a time, two dependent
// reads on a single memory read port, result or fault on a response channel.
// Assumes 4-byte entries with frame number in the upper bits and the present
// flag in bit 0, and a memory that answers each read exactly once.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PA_W     = 32,
    parameter int IDX_W    = 10,
    parameter int OFF_W    = 12,
    parameter int ENT_LOG2 = 2,
    localparam int VA_W    = 2 * IDX_W + OFF_W,
    localparam int N_LVL   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] root_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [PA_W-1:0] mem_rdata,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_fault,
    output logic            rsp_level,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [VA_W-1:0] rsp_vaddr
);

    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  root_q;
    logic [PA_W-1:0]  sec_base_q;
    walk_level_e      read_level;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] sec_idx;
    logic [OFF_W-1:0] page_off;
    logic [PA_W-1:0]  lvl_base [N_LVL];
    logic [IDX_W-1:0] lvl_idx  [N_LVL];
    logic [PA_W-1:0]  lvl_addr [N_LVL];

    pt_va_split #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .vaddr    (va_q),
        .top_idx  (top_idx),
        .sec_idx  (sec_idx),
        .page_off (page_off)
    );

    // Per-level table base and index selection
    always_comb begin
        lvl_base[0] = root_q;
        lvl_idx[0]  = top_idx;
        lvl_base[1] = sec_base_q;
        lvl_idx[1]  = sec_idx;
    end

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        pt_entry_addr #(
            .PA_W     (PA_W),
            .IDX_W    (IDX_W),
            .ENT_LOG2 (ENT_LOG2)
        ) u_addr (
            .table_base (lvl_base[g]),
            .index      (lvl_idx[g]),
            .entry_addr (lvl_addr[g])
        );
    end

    pt_walk_ctrl #(.PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .root_base  (root_base),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .read_level (read_level),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .rsp_ready  (rsp_ready),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_level  (rsp_level),
        .rsp_paddr  (rsp_paddr),
        .va_q       (va_q),
        .root_q     (root_q),
        .sec_base_q (sec_base_q)
    );

    // Read address of the level being walked; response echoes the request
    always_comb begin
        mem_addr  = (read_level == LVL_SECOND) ? lvl_addr[1] : lvl_addr[0];
        rsp_vaddr = va_q;
    end

endmodule

// File: rtl/pt_walker_chk.sv
// Module: pt_walker_chk
// Temporal checks on the walker's ports, attached to every pt_walker by bind.
// Assumes the same parameters as the walker it is bound to.
module pt_walker_chk #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int VA_W = 2 * IDX_W + OFF_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic [PA_W-1:0] mem_rdata,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic            rsp_level,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [VA_W-1:0] rsp_vaddr
);

    // R9: idle, reading and responding never overlap
    p_phase_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req, rsp_valid}));

    // R2: an accepted request starts a read on the next cycle
    p_accept_starts_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req);

    // R8: an unanswered read keeps its address
    p_read_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R5 and R6: an absent entry ends the walk with a zero-address fault
    p_absent_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rvalid && !mem_rdata[0] |=> rsp_valid && rsp_fault && (rsp_paddr == '0));

    // R4: a successful result keeps the page offset
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]) && !rsp_level);

    // R9: a stalled result does not move
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                                    && $stable(rsp_level) && $stable(rsp_vaddr));

    // R9: a taken result frees the walker
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_level;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_vaddr;

    int n_cmp = 0;
    int n_bad = 0;

    // memory model controls
    int          mode = 1;      // 0 random, 1 all present, 2 top absent, 3 second absent
    int          max_lat = 0;
    int          wait_cnt = 0;
    logic [31:0] salt = 32'h1234_5678;
    bit          stray = 1'b0;
    bit          pend = 1'b0;
    bit          stab_err = 1'b0;
    logic [31:0] first_addr = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [2];

    always #5 clk = ~clk;

    pt_walker dut (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a, input int lvl);
        logic [31:0] h;
        h = (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ salt;
        case (mode)
            1: h[0] = 1'b1;
            2: h[0] = (lvl == 0) ? 1'b0 : 1'b1;
            3: h[0] = (lvl == 0) ? 1'b1 : 1'b0;
            default: ;
        endcase
        return h;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // memory responder, acts at falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (!pend) begin
                    pend = 1'b1;
                    first_addr = mem_addr;
                end else if (mem_addr !== first_addr) begin
                    stab_err = 1'b1;
                end
                if (wait_cnt == 0) begin
                    if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
                    mem_rdata  = mem_word(mem_addr, rd_cnt);
                    mem_rvalid = 1'b1;
                    rd_cnt++;
                    pend = 1'b0;
                    wait_cnt = $urandom_range(max_lat, 0);
                end else begin
                    wait_cnt--;
                end
            end else if (stray) begin
                mem_rdata  = 32'h0;
                mem_rvalid = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] root, input int hold);
        logic [31:0] oa, ia, e1, e2, ex_pa;
        logic        ex_f, ex_l;
        int          ex_n;
        logic [31:0] pa0;
        // expected result from the requirements
        oa = root + {20'b0, va[31:22], 2'b00};
        e1 = mem_word(oa, 0);
        ia = '0;
        if (!e1[0]) begin
            ex_f = 1; ex_l = 0; ex_pa = '0; ex_n = 1;
        end else begin
            ia = {e1[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
            e2 = mem_word(ia, 1);
            ex_n = 2;
            if (!e2[0]) begin ex_f = 1; ex_l = 1; ex_pa = '0; end
            else begin ex_f = 0; ex_l = 0; ex_pa = {e2[31:12], va[11:0]}; end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0; stab_err = 1'b0; pend = 1'b0;
        wait_cnt = $urandom_range(max_lat, 0);
        req_vaddr = va; root_base = root; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va;
        root_base = ~root;           // R10: must not affect this walk
        chk("R9 busy after accept", {31'b0, req_ready}, 32'd0);
        while (!rsp_valid) @(negedge clk);
        pa0 = rsp_paddr;
        for (int i = 0; i < hold; i++) begin
            stray = (i == 0);        // R8: stray read pulse while idle-on-port
            @(negedge clk);
            stray = 1'b0;
            chk("R9 hold valid", {31'b0, rsp_valid}, 32'd1);
            chk("R9 hold paddr", rsp_paddr, pa0);
            chk("R9 no accept", {31'b0, req_ready}, 32'd0);
        end
        chk("R4 R5 R6 fault", {31'b0, rsp_fault}, {31'b0, ex_f});
        chk("R5 R6 level", {31'b0, rsp_level}, {31'b0, ex_l});
        chk("R4 R10 R11 paddr", rsp_paddr, ex_pa);
        chk("R7 vaddr", rsp_vaddr, va);
        chk("R5 R3 read count", rd_cnt, ex_n);
        chk("R2 top addr", rd_addr[0], oa);
        if (ex_n == 2) chk("R3 second addr", rd_addr[1], ia);
        chk("R8 addr stable", {31'b0, stab_err}, 32'd0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 release", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);

        // directed corners
        mode = 1; max_lat = 0;
        walk(32'h0000_0000, 32'h0004_0000, 0);
        walk(32'hFFFF_FFFF, 32'h0010_0000, 1);
        max_lat = 4;
        walk(32'h1234_5ABC, 32'h0020_0000, 3);
        mode = 2;
        walk(32'hDEAD_BEEF, 32'h0030_0000, 2);   // R5
        mode = 3;
        walk(32'h8040_2001, 32'h0040_0000, 2);   // R6
        mode = 1; salt = 32'h0000_0FFE;          // R11: junk in bits 11:1
        walk(32'h7FC0_0FFF, 32'h0050_0000, 0);

        // constrained random
        void'($urandom(32'd20240611));
        for (int t = 0; t < 300; t++) begin
            mode    = ($urandom_range(3, 0) == 0) ? 1 : 0;
            max_lat = $urandom_range(5, 0);
            salt    = $urandom();
            walk($urandom(), {$urandom_range(32'hFFFFF, 0), 12'h000}, $urandom_range(3, 0));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule